// File: doc/BRIEF.md
# Card Slot Power Switch Controller

This block is the digital control core of a single-slot card power switch. A host controller loads an 11-bit command over three slow serial lines: a data line, a bit clock and a load strobe. The block keeps the last loaded command in an active register and turns it into enable signals for the analog switches. The card-core rail can close a 3.3 V path, a 5 V path or a discharge-to-ground path. The programming rail can close a 3.3 V, 5 V or 12 V path, or its own discharge path.

Several conditions override the command. A card reset pin and an internal power-on flag ground both rails. A shutdown pin, the shutdown bit of the command, and an undervoltage flag open every switch. An overtemperature flag opens every supply path. When the selected path on a rail changes, the old switch opens and an all-open dead time passes before the new switch closes. An active-low fault output reports any overcurrent or overtemperature flag. The serial lines are sampled by a fast system clock through synchronizers.

Top module: `card_pwr_ctrl`

## Requirements
- R1: The word is shifted in most significant bit first (D10 first, D0 last), one bit per rising edge of `ser_clk`. A rising edge of `ser_latch` copies the 11 shifted bits into the active register. Bit D10 has no effect on any output.
- R2: With D8 = 1 and no override, D3:D2 select the programming rail. `prog_en` bit 0 is 3.3 V, bit 1 is 5 V, bit 2 is 12 V and bit 3 is discharge. Code 00 gives discharge, 01 gives 3.3 V, 10 gives 5 V and 11 gives 12 V.
- R3: With D8 = 1 and no override, D0, D1 and D9 select the card-core rail. `core_en` bit 0 is 3.3 V, bit 1 is 5 V and bit 2 is discharge. D0=0 with D1=1 gives 5 V when D9=1 and 3.3 V when D9=0. D0 equal to D1 gives discharge. D0=1 with D1=0 leaves every core switch open.
- R4: A latched word with D8 = 0 opens every switch on both rails.
- R5: While `shdn_n` is low, every switch is open. When it returns high, the latched selection is restored.
- R6: While `card_rst_n` is low or `por_flag` is high, only the two discharge switches may be closed. A latch strobe during that time is ignored.
- R7: After the system reset, and after a card reset or power-on condition ends, both rails stay on discharge until a new word is latched.
- R8: While `uvlo_flag` is high, every switch is open, whatever the other inputs are.
- R9: While `ot_flag` is high, every supply path is open. A discharge selection stays in effect.
- R10: `fault_n` is low exactly when `ot_flag` or any bit of `oc_flags` is high.
- R11: At most one switch per rail is closed at any time. When a rail moves from one closed switch to a different one, all of that rail's switches stay open for at least DEAD_CYC system clock cycles in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_data | input | 1 | Serial command data |
| ser_latch | input | 1 | Load strobe, active on rising edge |
| card_rst_n | input | 1 | Active-low card reset, grounds both rails |
| shdn_n | input | 1 | Active-low shutdown, opens all switches |
| por_flag | input | 1 | Supply too low for operation, acts as card reset |
| uvlo_flag | input | 1 | Undervoltage lockout, opens all switches |
| ot_flag | input | 1 | Overtemperature, opens supply paths |
| oc_flags | input | NUM_OC | Per-path overcurrent flags |
| core_en | output | 3 | Card-core switch enables {discharge, 5 V, 3.3 V} |
| prog_en | output | 4 | Programming rail enables {discharge, 12 V, 5 V, 3.3 V} |
| fault_n | output | 1 | Active-low fault, drives the open-drain pad low |

## Verification
The bench builds the block with DEAD_CYC = 6, NUM_OC = 3 and SYNC_STAGES = 2. A dead time of six cycles is long enough that a missing or shortened all-open gap shows up clearly, and short enough for every decode row to be swept well within the run. Three overcurrent flags test the OR reduction over more than one bit. Two synchronizer stages keep the latency from serial edges to outputs realistic, and that latency sets how long the bench waits before it samples.

// File: rtl/cpsw_pkg.sv
`timescale 1ns/1ps
package cpsw_pkg;

    localparam int WORD_W    = 11;
    localparam int B_CORE_A  = 0;
    localparam int B_CORE_B  = 1;
    localparam int B_PROG_LO = 2;
    localparam int B_PROG_HI = 3;
    localparam int B_RUN     = 8;
    localparam int B_CORE_HV = 9;

    typedef logic [WORD_W-1:0] word_t;

    // Word that grounds both rails: run bit set, all selection codes zero.
    localparam word_t GROUND_WORD = word_t'(1) << B_RUN;

    typedef enum logic [2:0] {
        CORE_OFF = 3'b000,
        CORE_V33 = 3'b001,
        CORE_V5  = 3'b010,
        CORE_GND = 3'b100
    } core_sel_e;

    typedef enum logic [3:0] {
        PROG_OFF = 4'b0000,
        PROG_V33 = 4'b0001,
        PROG_V5  = 4'b0010,
        PROG_V12 = 4'b0100,
        PROG_GND = 4'b1000
    } prog_sel_e;

    typedef struct packed {
        core_sel_e core;
        prog_sel_e prog;
    } sel_t;

    function automatic core_sel_e decode_core(input logic a, input logic b, input logic hv);
        core_sel_e r;
        if (!a && b)      r = hv ? CORE_V5 : CORE_V33;
        else if (a == b)  r = CORE_GND;
        else              r = CORE_OFF;
        return r;
    endfunction

    function automatic prog_sel_e decode_prog(input logic [1:0] code);
        prog_sel_e r;
        case (code)
            2'b00:   r = PROG_GND;
            2'b01:   r = PROG_V33;
            2'b10:   r = PROG_V5;
            default: r = PROG_V12;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpsw_sync.sv
`timescale 1ns/1ps
module cpsw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/cpsw_serial_rx.sv
`timescale 1ns/1ps
module cpsw_serial_rx
    import cpsw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ser_clk,
    input  logic  ser_data,
    input  logic  ser_latch,
    input  logic  hold,
    output word_t word_q
);
    logic [2:0] raw, syn;
    logic       prev_clk, prev_latch;
    logic       clk_rise, latch_rise;
    word_t      shift_q;

    assign raw = {ser_latch, ser_clk, ser_data};

    cpsw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .dout (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk   <= 1'b0;
            prev_latch <= 1'b0;
        end else begin
            prev_clk   <= syn[1];
            prev_latch <= syn[2];
        end
    end

    assign clk_rise   = syn[1] & ~prev_clk;
    assign latch_rise = syn[2] & ~prev_latch;

    // First bit shifted ends up in the top position.
    always_ff @(posedge clk) begin
        if (rst)           shift_q <= '0;
        else if (clk_rise) shift_q <= {shift_q[WORD_W-2:0], syn[0]};
    end

    // Card reset or power-on condition pins the register to the grounded word.
    always_ff @(posedge clk) begin
        if (rst || hold)     word_q <= GROUND_WORD;
        else if (latch_rise) word_q <= shift_q;
    end
endmodule

// File: rtl/cpsw_arbiter.sv
`timescale 1ns/1ps
module cpsw_arbiter
    import cpsw_pkg::*;
(
    input  word_t word_q,
    input  logic  uvlo,
    input  logic  hold,
    input  logic  shdn_n,
    input  logic  ot,
    output sel_t  tgt
);
    logic open_all;
    core_sel_e core_d;
    prog_sel_e prog_d;

    assign open_all = !shdn_n || !word_q[B_RUN];
    assign core_d   = decode_core(word_q[B_CORE_A], word_q[B_CORE_B], word_q[B_CORE_HV]);
    assign prog_d   = decode_prog(word_q[B_PROG_HI:B_PROG_LO]);

    always_comb begin
        tgt.core = CORE_OFF;
        tgt.prog = PROG_OFF;
        if (!uvlo) begin
            if (hold) begin
                tgt.core = CORE_GND;
                tgt.prog = PROG_GND;
            end else if (!open_all) begin
                tgt.core = core_d;
                tgt.prog = prog_d;
                if (ot) begin
                    if (core_d != CORE_GND) tgt.core = CORE_OFF;
                    if (prog_d != PROG_GND) tgt.prog = PROG_OFF;
                end
            end
        end
    end
endmodule

// File: rtl/cpsw_bbm.sv
`timescale 1ns/1ps
module cpsw_bbm #(
    parameter int W        = 3,
    parameter int DEAD_CYC = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tgt,
    output logic [W-1:0] out_en
);
    localparam int CW = $clog2(DEAD_CYC + 2);
    localparam logic [CW-1:0] DEAD = CW'(DEAD_CYC);

    logic [W-1:0]  cur;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            cnt <= '0;
        end else if (cur != tgt) begin
            if (cur != '0) begin
                cur <= '0;
                cnt <= DEAD;
            end else if (cnt == '0) begin
                cur <= tgt;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // A switch that no longer matches the target opens without waiting for a clock.
    assign out_en = cur & tgt;

    // Checker state: consecutive all-open samples and last closed switch.
    logic [CW-1:0] gap;
    logic [W-1:0]  last_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= DEAD;
            last_on <= '0;
        end else if (out_en != '0) begin
            gap     <= '0;
            last_on <= out_en;
        end else if (gap < DEAD) begin
            gap <= gap + 1'b1;
        end
    end

    p_one_switch_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_en));

    p_no_direct_swap_r11: assert property (@(posedge clk) disable iff (rst)
        ((out_en != '0) && ($past(out_en) != '0)) |-> (out_en == $past(out_en)));

    p_dead_time_r11: assert property (@(posedge clk) disable iff (rst)
        ((out_en != '0) && ($past(out_en) == '0) && (out_en != last_on)) |-> (gap >= DEAD));
endmodule

// File: rtl/card_pwr_ctrl.sv
`timescale 1ns/1ps
module card_pwr_ctrl
    import cpsw_pkg::*;
#(
    parameter int DEAD_CYC    = 4,
    parameter int NUM_OC      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    input  logic              card_rst_n,
    input  logic              shdn_n,
    input  logic              por_flag,
    input  logic              uvlo_flag,
    input  logic              ot_flag,
    input  logic [NUM_OC-1:0] oc_flags,
    output logic [2:0]        core_en,
    output logic [3:0]        prog_en,
    output logic              fault_n
);
    logic  hold;
    word_t word_q;
    sel_t  tgt;

    assign hold = por_flag || !card_rst_n;

    cpsw_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .hold      (hold),
        .word_q    (word_q)
    );

    cpsw_arbiter u_arb (
        .word_q (word_q),
        .uvlo   (uvlo_flag),
        .hold   (hold),
        .shdn_n (shdn_n),
        .ot     (ot_flag),
        .tgt    (tgt)
    );

    cpsw_bbm #(.W(3), .DEAD_CYC(DEAD_CYC)) u_bbm_core (
        .clk    (clk),
        .rst    (rst),
        .tgt    (tgt.core),
        .out_en (core_en)
    );

    cpsw_bbm #(.W(4), .DEAD_CYC(DEAD_CYC)) u_bbm_prog (
        .clk    (clk),
        .rst    (rst),
        .tgt    (tgt.prog),
        .out_en (prog_en)
    );

    assign fault_n = !(ot_flag || (|oc_flags));

    p_uvlo_open_r8: assert property (@(posedge clk) disable iff (rst)
        uvlo_flag |-> (core_en == '0 && prog_en == '0));

    p_reset_ground_only_r6: assert property (@(posedge clk) disable iff (rst)
        (!card_rst_n || por_flag) |-> (core_en[1:0] == '0 && prog_en[2:0] == '0));

    p_shutdown_open_r5: assert property (@(posedge clk) disable iff (rst)
        (!shdn_n && card_rst_n && !por_flag) |-> (core_en == '0 && prog_en == '0));

    p_overtemp_supply_open_r9: assert property (@(posedge clk) disable iff (rst)
        ot_flag |-> (core_en[1:0] == '0 && prog_en[2:0] == '0));
endmodule

// File: tb/card_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module card_pwr_ctrl_tb_top;
    localparam int DEAD   = 6;
    localparam int NOC    = 3;
    localparam int SETTLE = DEAD + 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
    logic card_rst_n = 1'b1, shdn_n = 1'b1;
    logic por_flag = 1'b0, uvlo_flag = 1'b0, ot_flag = 1'b0;
    logic [NOC-1:0] oc_flags = '0;
    logic [2:0] core_en;
    logic [3:0] prog_en;
    logic fault_n;

    always #2.5 clk = ~clk;

    card_pwr_ctrl #(.DEAD_CYC(DEAD), .NUM_OC(NOC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch),
        .card_rst_n(card_rst_n), .shdn_n(shdn_n), .por_flag(por_flag), .uvlo_flag(uvlo_flag),
        .ot_flag(ot_flag), .oc_flags(oc_flags), .core_en(core_en), .prog_en(prog_en),
        .fault_n(fault_n)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [2:0] c;
        logic [3:0] p;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    // Rail tracking for the dead-time and one-switch rule (R11).
    logic [2:0] last_c = '0;
    logic [3:0] last_p = '0;
    int run_c = 0, run_p = 0, swaps_c = 0, swaps_p = 0, gap_viol = 0, oh_viol = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if ($countones(core_en) > 1 || $countones(prog_en) > 1) oh_viol++;
            if (core_en == '0) run_c++;
            else begin
                if (last_c != '0 && core_en != last_c) begin
                    swaps_c++;
                    if (run_c < DEAD) gap_viol++;
                end
                last_c = core_en;
                run_c  = 0;
            end
            if (prog_en == '0) run_p++;
            else begin
                if (last_p != '0 && prog_en != last_p) begin
                    swaps_p++;
                    if (run_p < DEAD) gap_viol++;
                end
                last_p = prog_en;
                run_p  = 0;
            end
        end
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if (core_en !== e.c || prog_en !== e.p) begin
                n_fail++;
                $display("FAIL %s: core_en=%b prog_en=%b expected core_en=%b prog_en=%b",
                         e.tag, core_en, prog_en, e.c, e.p);
            end
        end
    end

    task automatic expect_out(input logic [2:0] c, input logic [3:0] p, input string tag);
        exp_t e;
        e.c = c; e.p = p; e.tag = tag;
        sb_q.push_back(e);
        while (sb_q.size() != 0) @(posedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] mk(input logic d0, input logic d1, input logic d9,
                                       input logic [1:0] pc, input logic d8, input logic d10);
        logic [10:0] w = '0;
        w[0] = d0; w[1] = d1; w[3:2] = pc; w[8] = d8; w[9] = d9; w[10] = d10;
        return w;
    endfunction

    // Expected selections written from R2 and R3.
    function automatic logic [2:0] exp_core(input logic [10:0] w);
        if (!w[0] && w[1]) return w[9] ? 3'b010 : 3'b001;
        if (w[0] == w[1])  return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [3:0] exp_prog(input logic [10:0] w);
        case (w[3:2])
            2'b00:   return 4'b1000;
            2'b01:   return 4'b0001;
            2'b10:   return 4'b0010;
            default: return 4'b0100;
        endcase
    endfunction

    task automatic send_word(input logic [10:0] w);
        for (int i = 10; i >= 0; i--) begin
            ser_data = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        ser_latch = 1'b1;
        repeat (4) @(negedge clk);
        ser_latch = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    logic done = 1'b0;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [10:0] w;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (SETTLE) @(negedge clk);
        expect_out(3'b100, 4'b1000, "R7 grounded after system reset");
        check(fault_n === 1'b1, "R10 no fault at reset", fault_n, 1);

        // R2 and R3: every decode row of both rails.
        for (int ci = 0; ci < 5; ci++) begin
            for (int pi = 0; pi < 4; pi++) begin
                case (ci)
                    0: w = mk(0, 0, 0, 2'(pi), 1, 0);
                    1: w = mk(0, 1, 0, 2'(pi), 1, 0);
                    2: w = mk(0, 1, 1, 2'(pi), 1, 0);
                    3: w = mk(1, 0, 0, 2'(pi), 1, 0);
                    default: w = mk(1, 1, 0, 2'(pi), 1, 0);
                endcase
                send_word(w);
                expect_out(exp_core(w), exp_prog(w), "R2 R3 decode row");
            end
        end

        // R1: D10 set has no effect.
        w = mk(0, 1, 1, 2'b11, 1, 1);
        send_word(w);
        expect_out(3'b010, 4'b0100, "R1 top bit ignored");

        // R4: run bit clear opens everything.
        send_word(mk(0, 1, 1, 2'b11, 0, 0));
        expect_out(3'b000, 4'b0000, "R4 shutdown bit");

        // R5: shutdown pin.
        send_word(mk(0, 1, 0, 2'b10, 1, 0));
        expect_out(3'b001, 4'b0010, "R5 before pin shutdown");
        shdn_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_out(3'b000, 4'b0000, "R5 pin shutdown");
        shdn_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
        expect_out(3'b001, 4'b0010, "R5 restored after shutdown");

        // R6 and R7: card reset, latch ignored.
        card_rst_n = 1'b0;
        repeat (SETTLE) @(negedge clk);
        expect_out(3'b100, 4'b1000, "R6 card reset grounds");
        send_word(mk(0, 1, 1, 2'b11, 1, 0));
        expect_out(3'b100, 4'b1000, "R6 latch ignored in reset");
        card_rst_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
        expect_out(3'b100, 4'b1000, "R7 grounded after card reset");
        send_word(mk(0, 1, 1, 2'b11, 1, 0));
        expect_out(3'b010, 4'b0100, "R7 new word after card reset");

        // R6 and R7: power-on flag.
        por_flag = 1'b1;
        repeat (SETTLE) @(negedge clk);
        expect_out(3'b100, 4'b1000, "R6 power-on flag grounds");
        por_flag = 1'b0;
        repeat (SETTLE) @(negedge clk);
        expect_out(3'b100, 4'b1000, "R7 grounded after power-on flag");

        // R8: lockout dominates everything.
        send_word(mk(0, 1, 1, 2'b11, 1, 0));
        uvlo_flag = 1'b1;
        repeat (3) @(negedge clk);
        expect_out(3'b000, 4'b0000, "R8 lockout opens all");
        por_flag = 1'b1;
        card_rst_n = 1'b0;
        repeat (SETTLE) @(negedge clk);
        expect_out(3'b000, 4'b0000, "R8 lockout over reset");
        por_flag = 1'b0;
        card_rst_n = 1'b1;
        uvlo_flag = 1'b0;
        repeat (SETTLE) @(negedge clk);
        expect_out(3'b100, 4'b1000, "R8 R7 released to ground");

        // R9 and R10: overtemperature.
        send_word(mk(0, 1, 1, 2'b11, 1, 0));
        ot_flag = 1'b1;
        repeat (3) @(negedge clk);
        expect_out(3'b000, 4'b0000, "R9 overtemp opens supplies");
        check(fault_n === 1'b0, "R10 fault on overtemp", fault_n, 0);
        send_word(mk(0, 0, 0, 2'b00, 1, 0));
        expect_out(3'b100, 4'b1000, "R9 discharge kept in overtemp");
        ot_flag = 1'b0;
        @(negedge clk);
        check(fault_n === 1'b1, "R10 fault clears", fault_n, 1);
        send_word(mk(0, 1, 0, 2'b01, 1, 0));
        expect_out(3'b001, 4'b0001, "R9 supplies back after overtemp");

        // R10: each overcurrent flag.
        for (int k = 0; k < NOC; k++) begin
            oc_flags = '0;
            oc_flags[k] = 1'b1;
            @(negedge clk);
            check(fault_n === 1'b0, "R10 fault on overcurrent", fault_n, 0);
            oc_flags = '0;
            @(negedge clk);
            check(fault_n === 1'b1, "R10 fault released", fault_n, 1);
        end

        // R11: direct supply swaps on both rails.
        send_word(mk(0, 1, 1, 2'b11, 1, 0));
        send_word(mk(0, 1, 0, 2'b10, 1, 0));
        expect_out(3'b001, 4'b0010, "R11 final selection after swap");
        check(gap_viol == 0, "R11 dead time kept", gap_viol, 0);
        check(oh_viol == 0, "R11 one switch per rail", oh_viol, 0);
        check(swaps_c > 0 && swaps_p > 0, "R11 swaps observed", swaps_c + swaps_p, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule